// File: doc/BRIEF.md
# Write-back cache miss controller

This block is a direct-mapped, write-back cache with its controller. It sits between a processor request port and a main memory whose latency is not known in advance. Each processor access is looked up through combinational logic. The lookup compares the stored tag and valid state against the request address, so a hit returns read data in the same cycle. A store hit writes the addressed word and marks its line dirty. On a miss the block stalls the processor and first copies the old line out to memory, but only when that line is both valid and dirty. It then reads the new eight-word line one word at a time. A single retry cycle follows, in which the access is looked up again. A store miss allocates: the line is filled first and the store is merged in the retry cycle.

Addresses are split into a byte offset of 2 bits (not carried on the processor port, since accesses are whole words), a word-in-line field of 3 bits, an index of `IDX_W` bits and a tag made of the remaining upper bits. The processor side works as a request/stall handshake. A request is taken at a rising edge where `cpu_req` is high and `cpu_stall` is low. While `cpu_stall` is high the processor must hold the request, the address and the write data unchanged. The memory side works as a request/ready handshake. One word moves at each rising edge where `mem_req` and `mem_ready` are both high, and the block holds address, direction and write data unchanged until that edge. Setting `WRITE_EN` to 0 turns the same block into a read-only cache, such as an instruction cache.

Top module: `cwb_cache_ctrl`

## Requirements
- R1: A read that hits returns the addressed word on `cpu_rdata` with `cpu_stall` low in the same cycle, and starts no memory transfer.
- R2: A miss raises `cpu_stall` in the cycle the request is presented. When the indexed line is not both valid and dirty, eight memory reads (`mem_we`=0) follow at the word addresses of the missing line, in ascending order from word 0 to word 7, and no memory write takes place.
- R3: After the last fill word has been accepted, `cpu_stall` stays high for exactly one more cycle (the retry cycle). It is low in the second cycle, with the requested word on `cpu_rdata`. The remaining seven words of the line then hit.
- R4: A store hit writes `cpu_wdata` into the addressed word without stalling and without memory traffic. A later read returns the stored value.
- R5: A miss to a line that is valid and dirty first issues eight memory writes (`mem_we`=1) of that line's words, in ascending order, at the addresses made from its old tag. Only after these come the eight reads of R2.
- R6: A store miss fills the line and then applies the store. A later read of the stored word returns the store data, and the other words of the line hold the memory contents.
- R7: While `mem_req` is high and `mem_ready` is low, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged at the next cycle.
- R8: The miss sequence advances only on `mem_ready`. Any number of wait cycles between words, including none, gives the same result.
- R9: After reset, `cpu_stall` and `mem_req` are low, and the first access to every line misses.
- R10: With `WRITE_EN`=0, stores change no cached word, never mark a line dirty and never cause a memory write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W-2 (30) | Word address (byte address bits ADDR_W-1 down to 2) |
| cpu_wdata | input | DATA_W (32) | Store data |
| cpu_rdata | output | DATA_W (32) | Load data, valid while `cpu_stall` is low |
| cpu_stall | output | 1 | Hold the current request |
| mem_req | output | 1 | Memory word transfer requested |
| mem_we | output | 1 | 1 = write to memory, 0 = read |
| mem_addr | output | ADDR_W (32) | Byte address of the word, low 2 bits zero |
| mem_wdata | output | DATA_W (32) | Word written to memory |
| mem_rdata | input | DATA_W (32) | Word read from memory, valid with `mem_ready` |
| mem_ready | input | 1 | Transfer of the current word completes at this edge |

## Verification
In a store miss to a dirty line, two functions act on one line in close succession. The old contents are read out for the write-back, and the store is merged into the refilled words in the retry cycle, right after the final fill beat has written the tag. The bench provokes this with store misses onto lines it has dirtied earlier, under zero-wait, random-wait and long-wait memory. It judges the result in two ways. The write-back beats must carry exactly the stored old words. Later reads must return the new store data merged with the memory words.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
  localparam int WORD_BITS = 3;
  localparam int LINE_WORDS = 1 << WORD_BITS;
  localparam int BYTE_BITS = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WBACK,
    ST_FILL,
    ST_RETRY
  } cwb_state_e;
endpackage

// File: rtl/cwb_tag_store.sv
module cwb_tag_store #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_en,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic             lk_victim_dirty,
  output logic [TAG_W-1:0] lk_victim_tag,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             dirty_we
);
  localparam int LINES = 1 << IDX_W;

  logic             vld [LINES];
  logic             drt [LINES];
  logic [TAG_W-1:0] tg  [LINES];

  // valid bits are the only state cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) vld[i] <= 1'b0;
    end else if (fill_we) begin
      vld[fill_idx] <= 1'b1;
    end
  end

  // tag and dirty bits start undefined
  always_ff @(posedge clk) begin
    if (fill_we) begin
      tg[fill_idx]  <= fill_tag;
      drt[fill_idx] <= 1'b0;
    end else if (dirty_we) begin
      drt[lk_idx] <= 1'b1;
    end
  end

  // reads happen only while the lookup is enabled
  always_comb begin
    lk_hit          = 1'b0;
    lk_victim_dirty = 1'b0;
    lk_victim_tag   = '0;
    if (lk_en) begin
      lk_hit          = vld[lk_idx] && (tg[lk_idx] == lk_tag);
      lk_victim_dirty = vld[lk_idx] && drt[lk_idx];
      lk_victim_tag   = tg[lk_idx];
    end
  end

  // the array has one port: no lookup while a fill writes the tag
  assert_tag_port_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> !lk_en);

  // R4: dirty marking only follows a hit
  assert_dirty_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dirty_we |-> lk_hit);
endmodule

// File: rtl/cwb_data_store.sv
module cwb_data_store #(
  parameter int IDX_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                         clk,
  input  logic [IDX_W-1:0]             idx,
  input  logic [cwb_pkg::WORD_BITS-1:0] word,
  input  logic                         we,
  input  logic [DATA_W-1:0]            wdata,
  output logic [DATA_W-1:0]            rdata
);
  localparam int DEPTH = (1 << IDX_W) * cwb_pkg::LINE_WORDS;

  logic [DATA_W-1:0] words_q [DEPTH];

  // single port: one address serves both read and write
  always_ff @(posedge clk) begin
    if (we) words_q[{idx, word}] <= wdata;
  end

  assign rdata = words_q[{idx, word}];
endmodule

// File: rtl/cwb_ctrl.sv
module cwb_ctrl
  import cwb_pkg::*;
#(
  parameter int IDX_W    = 4,
  parameter int TAG_W    = 23,
  parameter bit WRITE_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_req,
  input  logic                 cpu_we_eff,
  input  logic [TAG_W-1:0]     cpu_tag,
  input  logic [IDX_W-1:0]     cpu_idx,
  input  logic [WORD_BITS-1:0] cpu_word,
  output logic                 cpu_stall,
  output logic                 lk_en,
  input  logic                 lk_hit,
  input  logic                 lk_victim_dirty,
  input  logic [TAG_W-1:0]     lk_victim_tag,
  output logic                 tag_fill,
  output logic [TAG_W-1:0]     fill_tag,
  output logic                 dirty_set,
  output logic [IDX_W-1:0]     arr_idx,
  output logic [WORD_BITS-1:0] arr_word,
  output logic                 arr_we,
  output logic                 arr_from_mem,
  output logic                 mem_req,
  output logic                 mem_we,
  output logic [TAG_W+IDX_W+WORD_BITS+BYTE_BITS-1:0] mem_addr,
  input  logic                 mem_ready
);
  localparam logic [WORD_BITS-1:0] LAST_WORD = WORD_BITS'(LINE_WORDS - 1);

  cwb_state_e           state;
  logic [WORD_BITS-1:0] cnt;
  logic [IDX_W-1:0]     midx;
  logic [TAG_W-1:0]     mtag;
  logic [TAG_W-1:0]     vtag;
  logic                 miss;
  logic                 acc_hit;
  logic                 beat;

  assign lk_en   = (state == ST_IDLE) || (state == ST_RETRY);
  assign miss    = (state == ST_IDLE) && cpu_req && !lk_hit;
  assign acc_hit = lk_en && cpu_req && lk_hit;
  assign beat    = mem_req && mem_ready;

  assign cpu_stall = miss || (state != ST_IDLE);

  assign dirty_set    = acc_hit && cpu_we_eff;
  assign arr_from_mem = (state == ST_FILL);
  assign arr_we       = (arr_from_mem && mem_ready) || dirty_set;
  assign arr_idx      = lk_en ? cpu_idx : midx;
  assign arr_word     = lk_en ? cpu_word : cnt;

  assign tag_fill = (state == ST_FILL) && mem_ready && (cnt == LAST_WORD);
  assign fill_tag = mtag;

  assign mem_req  = (state == ST_WBACK) || (state == ST_FILL);
  assign mem_we   = (state == ST_WBACK);
  assign mem_addr = {(state == ST_WBACK) ? vtag : mtag, midx, cnt, {BYTE_BITS{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      midx  <= '0;
      mtag  <= '0;
      vtag  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (miss) begin
            midx  <= cpu_idx;
            mtag  <= cpu_tag;
            vtag  <= lk_victim_tag;
            cnt   <= '0;
            state <= (WRITE_EN && lk_victim_dirty) ? ST_WBACK : ST_FILL;
          end
        end
        ST_WBACK: begin
          if (mem_ready) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_WORD) state <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ready) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_WORD) state <= ST_RETRY;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: a hit in normal operation starts no memory transfer
  assert_no_mem_on_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && cpu_req && lk_hit) |=> !mem_req);

  // R3: after the last fill beat the processor stays stalled for the retry
  assert_retry_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tag_fill |=> cpu_stall && !mem_req);

  // R3: the replayed access must hit
  assert_retry_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RETRY && cpu_req) |-> lk_hit);

  // R5: a write-back starts only for a line found valid and dirty
  assert_wb_needs_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(lk_victim_dirty));

  // R7: a pending word transfer holds its address and direction
  assert_mem_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R8: words advance only with ready
  assert_beat_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> $stable(cnt));

  if (!WRITE_EN) begin : g_ro_chk
    // R10: a read-only cache never writes memory or marks lines dirty
    assert_ro_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we && !dirty_set);
  end
endmodule

// File: rtl/cwb_cache_ctrl.sv
module cwb_cache_ctrl
  import cwb_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int IDX_W    = 4,
  parameter bit WRITE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:2] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ready
);
  localparam int IDX_LO = BYTE_BITS + WORD_BITS;
  localparam int TAG_LO = IDX_LO + IDX_W;
  localparam int TAG_W  = ADDR_W - TAG_LO;

  logic [TAG_W-1:0]     cpu_tag;
  logic [IDX_W-1:0]     cpu_idx;
  logic [WORD_BITS-1:0] cpu_word;
  logic                 cpu_we_eff;

  logic                 lk_en;
  logic                 lk_hit;
  logic                 lk_victim_dirty;
  logic [TAG_W-1:0]     lk_victim_tag;
  logic                 tag_fill;
  logic [TAG_W-1:0]     fill_tag;
  logic                 dirty_set;
  logic [IDX_W-1:0]     arr_idx;
  logic [WORD_BITS-1:0] arr_word;
  logic                 arr_we;
  logic                 arr_from_mem;
  logic [DATA_W-1:0]    arr_wdata;
  logic [DATA_W-1:0]    arr_rdata;

  assign cpu_word   = cpu_addr[IDX_LO-1:BYTE_BITS];
  assign cpu_idx    = cpu_addr[TAG_LO-1:IDX_LO];
  assign cpu_tag    = cpu_addr[ADDR_W-1:TAG_LO];
  assign cpu_we_eff = cpu_we && WRITE_EN;

  assign arr_wdata = arr_from_mem ? mem_rdata : cpu_wdata;
  assign cpu_rdata = arr_rdata;
  assign mem_wdata = arr_rdata;

  cwb_ctrl #(
    .IDX_W    (IDX_W),
    .TAG_W    (TAG_W),
    .WRITE_EN (WRITE_EN)
  ) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .cpu_req         (cpu_req),
    .cpu_we_eff      (cpu_we_eff),
    .cpu_tag         (cpu_tag),
    .cpu_idx         (cpu_idx),
    .cpu_word        (cpu_word),
    .cpu_stall       (cpu_stall),
    .lk_en           (lk_en),
    .lk_hit          (lk_hit),
    .lk_victim_dirty (lk_victim_dirty),
    .lk_victim_tag   (lk_victim_tag),
    .tag_fill        (tag_fill),
    .fill_tag        (fill_tag),
    .dirty_set       (dirty_set),
    .arr_idx         (arr_idx),
    .arr_word        (arr_word),
    .arr_we          (arr_we),
    .arr_from_mem    (arr_from_mem),
    .mem_req         (mem_req),
    .mem_we          (mem_we),
    .mem_addr        (mem_addr),
    .mem_ready       (mem_ready)
  );

  cwb_tag_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_tags (
    .clk             (clk),
    .rst_n           (rst_n),
    .lk_en           (lk_en),
    .lk_idx          (cpu_idx),
    .lk_tag          (cpu_tag),
    .lk_hit          (lk_hit),
    .lk_victim_dirty (lk_victim_dirty),
    .lk_victim_tag   (lk_victim_tag),
    .fill_we         (tag_fill),
    .fill_idx        (arr_idx),
    .fill_tag        (fill_tag),
    .dirty_we        (dirty_set)
  );

  cwb_data_store #(
    .IDX_W  (IDX_W),
    .DATA_W (DATA_W)
  ) u_data (
    .clk   (clk),
    .idx   (arr_idx),
    .word  (arr_word),
    .we    (arr_we),
    .wdata (arr_wdata),
    .rdata (arr_rdata)
  );

  // R9: nothing is requested from memory while idle after reset
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_stall |-> !mem_req);
endmodule

// File: tb/tb_cwb_cache_ctrl.sv
module tb_cwb_cache_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  always #5ns clk = ~clk;

  logic        cpu_req, cpu_we;
  logic [29:0] cpu_addr;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;

  logic        ro_req, ro_we, ro_stall;
  logic [29:0] ro_addr;
  logic [31:0] ro_wdata, ro_rdata;
  logic        ro_mreq, ro_mwe, ro_mready;
  logic [31:0] ro_maddr, ro_mwdata, ro_mrdata;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_beat_cyc = 0;
  int lat_mode = 1;
  int ro_writes = 0;

  // reference state
  logic [31:0] mem [int unsigned];
  bit          rvalid [16];
  bit          rdirty [16];
  logic [22:0] rtag   [16];
  logic [31:0] rline  [16][8];
  bit          eq_we   [$];
  logic [29:0] eq_addr [$];
  logic [31:0] eq_data [$];

  function automatic logic [31:0] hsh(input logic [29:0] a);
    return ({2'b00, a} * 32'h9E3779B1) + 32'h01234567;
  endfunction

  function automatic logic [31:0] memrd(input logic [29:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return hsh(a);
  endfunction

  function automatic logic [29:0] mk(input int t, input int i, input int w);
    logic [22:0] tt;
    logic [3:0]  ii;
    logic [2:0]  ww;
    tt = 23'(t);
    ii = 4'(i);
    ww = 3'(w);
    return {tt, ii, ww};
  endfunction

  function automatic int lat();
    if (lat_mode == 0) return 0;
    if (lat_mode == 1) return $urandom_range(3, 0);
    return 9;
  endfunction

  cwb_cache_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_stall(cpu_stall), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready)
  );

  cwb_cache_ctrl #(.WRITE_EN(1'b0)) dut_ro (
    .clk(clk), .rst_n(rst_n), .cpu_req(ro_req), .cpu_we(ro_we),
    .cpu_addr(ro_addr), .cpu_wdata(ro_wdata), .cpu_rdata(ro_rdata),
    .cpu_stall(ro_stall), .mem_req(ro_mreq), .mem_we(ro_mwe),
    .mem_addr(ro_maddr), .mem_wdata(ro_mwdata), .mem_rdata(ro_mrdata),
    .mem_ready(ro_mready)
  );

  assign ro_mready = ro_mreq;
  assign ro_mrdata = hsh(ro_maddr[31:2]);

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && ro_mreq && ro_mwe) ro_writes <= ro_writes + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory model with variable wait states
  initial begin
    int          wait_n;
    bit          pend;
    logic [31:0] p_addr, p_wd;
    logic        p_we;
    mem_ready = 1'b0;
    mem_rdata = '0;
    pend = 1'b0;
    wait_n = 0;
    p_addr = '0;
    p_wd = '0;
    p_we = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req && pend) begin
        chk(mem_addr == p_addr, "R7", "held address", mem_addr, p_addr);
        chk(mem_we == p_we, "R7", "held direction", mem_we, p_we);
        if (p_we) chk(mem_wdata == p_wd, "R7", "held write data", mem_wdata, p_wd);
      end
      if (rst_n && mem_req) begin
        if (wait_n == 0) begin
          logic [29:0] a;
          a = mem_addr[31:2];
          if (eq_we.size() == 0) begin
            chk(1'b0, "R1", "unexpected memory transfer", mem_addr, 0);
          end else begin
            bit          e_we;
            logic [29:0] e_a;
            logic [31:0] e_d;
            e_we = eq_we.pop_front();
            e_a  = eq_addr.pop_front();
            e_d  = eq_data.pop_front();
            chk(mem_we == e_we, "R2 R5", "beat direction", mem_we, e_we);
            chk(a == e_a, "R2 R5", "beat word address", a, e_a);
            if (mem_we) begin
              chk(mem_wdata == e_d, "R5", "write-back data", mem_wdata, e_d);
              mem[int'(a)] = mem_wdata;
            end
          end
          mem_rdata = memrd(a);
          mem_ready = 1'b1;
          pend = 1'b0;
          last_beat_cyc = cyc;
          wait_n = lat();
        end else begin
          mem_ready = 1'b0;
          wait_n--;
          pend = 1'b1;
          p_addr = mem_addr;
          p_we = mem_we;
          p_wd = mem_wdata;
        end
      end else begin
        mem_ready = 1'b0;
        pend = 1'b0;
      end
    end
  end

  task automatic acc(input bit we, input logic [29:0] a, input logic [31:0] wd,
                     input string req);
    int   idx, w, n;
    bit   hit;
    logic [22:0] t;
    idx = int'(a[6:3]);
    w   = int'(a[2:0]);
    t   = a[29:7];
    @(negedge clk);
    cpu_req = 1'b1;
    cpu_we = we;
    cpu_addr = a;
    cpu_wdata = wd;
    #1ns;
    hit = rvalid[idx] && (rtag[idx] == t);
    chk(cpu_stall == !hit, req, "stall on lookup", cpu_stall, !hit);
    if (!hit) begin
      if (rvalid[idx] && rdirty[idx]) begin
        for (int k = 0; k < 8; k++) begin
          eq_we.push_back(1'b1);
          eq_addr.push_back({rtag[idx], 4'(idx), 3'(k)});
          eq_data.push_back(rline[idx][k]);
        end
      end
      for (int k = 0; k < 8; k++) begin
        eq_we.push_back(1'b0);
        eq_addr.push_back({t, 4'(idx), 3'(k)});
        eq_data.push_back('0);
      end
      n = 0;
      while (cpu_stall && n < 3000) begin
        @(negedge clk);
        #1ns;
        n++;
      end
      chk(!cpu_stall, req, "miss completes", cpu_stall, 0);
      chk(eq_we.size() == 0, req, "all line beats seen", eq_we.size(), 0);
      chk(cyc == last_beat_cyc + 2, "R3", "one retry cycle after fill", cyc, last_beat_cyc + 2);
      rvalid[idx] = 1'b1;
      rdirty[idx] = 1'b0;
      rtag[idx] = t;
      for (int k = 0; k < 8; k++) rline[idx][k] = memrd({t, 4'(idx), 3'(k)});
    end
    if (we) begin
      rline[idx][w] = wd;
      rdirty[idx] = 1'b1;
    end else begin
      chk(cpu_rdata == rline[idx][w], req, "load data", cpu_rdata, rline[idx][w]);
    end
  endtask

  task automatic ro_acc(input bit we, input logic [29:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output bit stalled);
    int n;
    @(negedge clk);
    ro_req = 1'b1;
    ro_we = we;
    ro_addr = a;
    ro_wdata = wd;
    #1ns;
    stalled = ro_stall;
    n = 0;
    while (ro_stall && n < 200) begin
      @(negedge clk);
      #1ns;
      n++;
    end
    rd = ro_rdata;
  endtask

  initial begin
    #1500us;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    bit          st;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    ro_req = 1'b0; ro_we = 1'b0; ro_addr = '0; ro_wdata = '0;
    for (int i = 0; i < 16; i++) begin
      rvalid[i] = 1'b0;
      rdirty[i] = 1'b0;
      rtag[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1ns;
    chk(cpu_stall == 1'b0, "R9", "stall after reset", cpu_stall, 0);
    chk(mem_req == 1'b0, "R9", "mem_req after reset", mem_req, 0);

    // R9: every line misses on its first access
    for (int i = 0; i < 16; i++) acc(1'b0, mk(5, i, i % 8), '0, "R9");

    // R3: the rest of a filled line hits
    for (int w = 0; w < 8; w++) acc(1'b0, mk(5, 2, w), '0, "R3");
    acc(1'b0, mk(5, 0, 1), '0, "R1");

    // R4: store hit then read back
    acc(1'b1, mk(5, 0, 3), 32'hCAFE0003, "R4");
    acc(1'b0, mk(5, 0, 3), '0, "R4");
    acc(1'b0, mk(5, 0, 4), '0, "R4");

    // R5: conflicting miss on the dirty line, then the old line comes back clean
    acc(1'b0, mk(9, 0, 0), '0, "R5");
    acc(1'b0, mk(5, 0, 3), '0, "R5");

    // R6: store miss with write-allocate, then eviction carries the merge
    acc(1'b1, mk(11, 5, 6), 32'h5EED0006, "R6");
    acc(1'b0, mk(11, 5, 6), '0, "R6");
    acc(1'b0, mk(11, 5, 7), '0, "R6");
    acc(1'b0, mk(12, 5, 0), '0, "R6");
    acc(1'b0, mk(11, 5, 6), '0, "R6");

    // R8: long waits and zero waits
    lat_mode = 2;
    acc(1'b1, mk(11, 5, 2), 32'h0B0B0002, "R8");
    acc(1'b1, mk(13, 5, 1), 32'h0C0C0001, "R8");
    acc(1'b0, mk(11, 5, 2), '0, "R8");
    lat_mode = 0;
    acc(1'b1, mk(14, 7, 0), 32'h0D0D0000, "R8");
    acc(1'b1, mk(15, 7, 7), 32'h0E0E0007, "R8");
    acc(1'b0, mk(14, 7, 0), '0, "R8");

    // mixed traffic under random waits
    lat_mode = 1;
    for (int k = 0; k < 150; k++) begin
      int t, i, w;
      t = 20 + $urandom_range(2, 0);
      i = $urandom_range(15, 0);
      w = $urandom_range(7, 0);
      acc(1'($urandom_range(1, 0)), mk(t, i, w), $urandom, "R5");
    end

    @(negedge clk);
    cpu_req = 1'b0;

    // R10: read-only variant
    ro_acc(1'b0, mk(3, 1, 2), '0, rd, st);
    chk(st == 1'b1, "R10", "read-only first access misses", st, 1);
    chk(rd == hsh(mk(3, 1, 2)), "R10", "read-only fill data", rd, hsh(mk(3, 1, 2)));
    ro_acc(1'b1, mk(3, 1, 2), 32'hDEAD0000, rd, st);
    chk(st == 1'b0, "R10", "store hit without stall", st, 0);
    ro_acc(1'b0, mk(3, 1, 2), '0, rd, st);
    chk(rd == hsh(mk(3, 1, 2)), "R10", "store ignored", rd, hsh(mk(3, 1, 2)));
    ro_acc(1'b1, mk(4, 6, 5), 32'hBEEF0000, rd, st);
    ro_acc(1'b0, mk(4, 6, 5), '0, rd, st);
    chk(rd == hsh(mk(4, 6, 5)), "R10", "store miss ignored", rd, hsh(mk(4, 6, 5)));
    ro_acc(1'b0, mk(8, 6, 0), '0, rd, st);
    ro_acc(1'b0, mk(8, 1, 0), '0, rd, st);
    @(negedge clk);
    ro_req = 1'b0;
    repeat (2) @(negedge clk);
    chk(ro_writes == 0, "R10", "read-only memory writes", ro_writes, 0);
    chk(eq_we.size() == 0, "R2", "no leftover expected beats", eq_we.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule